// File: doc/BRIEF.md
# Serial Clock Glitch Detector

This block watches the externally supplied receive and transmit clocks of a serial channel for glitches. Each clock is sampled by the faster system clock through a two-flop synchronizer. It then passes through a noise filter that drops any spike seen in only one sample. The filtered clock is timed from edge to edge. When a level lasts fewer system cycles than the programmed minimum for that level, the block records a glitch on that channel. The minimum high time and the minimum low time are set separately.

A glitch sets a sticky flag for its channel and advances a saturating event counter for debugging. Each flag has its own interrupt mask, and the masked flags are ORed into one interrupt request. Detection is purely a report: the serial clocks are never gated or altered, so the receiver and transmitter keep running. Detection works only while the enable input is high. The first edge after the enable is raised only starts the timing and is never judged.

Top module: `serial_clk_glitch_mon`

## Requirements
- R1: While reset is asserted and right after it is released, both glitch flags, the interrupt request and both event counters are zero.
- R2: A serial clock value that differs from its neighbours for exactly one system-clock sample is discarded by the filter, so it sets no flag and changes no counter.
- R3: When the filtered clock leaves the high level after fewer than minHighCyc system cycles, the flag of that channel is set and its counter increments. A high level held for minHighCyc cycles or more sets nothing.
- R4: When the filtered clock leaves the low level after fewer than minLowCyc system cycles, the flag of that channel is set and its counter increments. A low level held for minLowCyc cycles or more sets nothing.
- R5: While glitchDetEn is low, no flag is set and no counter changes. The first filtered edge after glitchDetEn rises is never judged, whatever the length of the level before it.
- R6: A glitch flag stays set until a one is applied to its clear input. If a clear and a new glitch fall in the same cycle, the flag stays set.
- R7: glitchIrq is high exactly when (rxGlitchFlag and rxIrqMask) or (txGlitchFlag and txIrqMask) holds. The masks act without delay on the interrupt only.
- R8: Each counter is CNT_W bits wide. It holds at all ones once it gets there and is cleared only by reset.
- R9: The receive and transmit channels are independent. A glitch on one never changes the flag or counter of the other.
- R10: Take the first system-clock rising edge that samples the serial clock transition ending a short level. The flag and counter change on the fourth rising edge counting from that one, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than either serial clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxSerClk | input | 1 | External receive serial clock |
| txSerClk | input | 1 | External transmit serial clock |
| glitchDetEn | input | 1 | Glitch detection enable |
| minHighCyc | input | PW_W | Minimum legal high time in system cycles |
| minLowCyc | input | PW_W | Minimum legal low time in system cycles |
| rxIrqMask | input | 1 | Passes the receive flag to the interrupt when high |
| txIrqMask | input | 1 | Passes the transmit flag to the interrupt when high |
| rxFlagClr | input | 1 | Clears the receive glitch flag when high |
| txFlagClr | input | 1 | Clears the transmit glitch flag when high |
| rxGlitchFlag | output | 1 | Sticky receive glitch flag |
| txGlitchFlag | output | 1 | Sticky transmit glitch flag |
| glitchIrq | output | 1 | Masked interrupt request |
| rxGlitchCnt | output | CNT_W | Saturating receive glitch count |
| txGlitchCnt | output | CNT_W | Saturating transmit glitch count |

## Verification
A serial clock change reaches the flags and counters after four system clock edges: two synchronizer stages, one filter agreement stage and the flag register. The bench therefore changes the serial clocks on falling system edges. For the timing requirement it samples the flag on the falling edge just before the fourth rising edge and again just after it. In the width sweeps, every level is held for at least 20 cycles after the pulse under test before anything is sampled, which is far longer than that latency. The mask result is combinational, so it is checked on the falling edge right after the masks change.

// File: rtl/sgm_pkg.sv
package sgm_pkg;

  localparam int NUM_CH = 2;
  localparam int CH_RX  = 0;
  localparam int CH_TX  = 1;

  // Per-cycle events reported by the datapath for each channel
  typedef struct packed {
    logic [NUM_CH-1:0] edgeSeen;   // filtered clock changed level
    logic [NUM_CH-1:0] shortLvl;   // level that just ended was too short
  } dpEvt_t;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic              armClr;     // forget the last edge, do not judge next
    logic [NUM_CH-1:0] cntInc;     // advance the event counter
  } ctlStb_t;

endpackage

// File: rtl/sgm_edge_timer.sv
module sgm_edge_timer #(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            serClkIn,
  input  logic            armClr,
  input  logic [PW_W-1:0] minHigh,
  input  logic [PW_W-1:0] minLow,
  output logic            edgeNow,
  output logic            shortNow
);

  localparam logic [PW_W-1:0] LVL_MAX = '1;

  logic            sync1, sync2, smpPrev, filtLvl, armed;
  logic [PW_W-1:0] lvlCnt;
  logic [PW_W-1:0] minSel;
  logic            agree;

  // two samples in a row must agree before the filtered level moves
  assign agree    = (sync2 == smpPrev);
  assign edgeNow  = agree && (sync2 != filtLvl);
  // the level being left decides which minimum applies
  assign minSel   = filtLvl ? minHigh : minLow;
  assign shortNow = armed && (lvlCnt < minSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      smpPrev <= 1'b0;
      filtLvl <= 1'b0;
    end else begin
      sync1   <= serClkIn;
      sync2   <= sync1;
      smpPrev <= sync2;
      if (edgeNow) filtLvl <= sync2;
    end
  end

  // cycles the filtered level has been held, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlCnt <= '0;
    end else if (edgeNow) begin
      lvlCnt <= PW_W'(1);
    end else if (lvlCnt != LVL_MAX) begin
      lvlCnt <= lvlCnt + PW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        armed <= 1'b0;
    else if (armClr)  armed <= 1'b0;
    else if (edgeNow) armed <= 1'b1;
  end

endmodule

// File: rtl/sgm_datapath.sv
module sgm_datapath
  import sgm_pkg::*;
#(
  parameter int PW_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             serClk,
  input  logic [PW_W-1:0]               minHigh,
  input  logic [PW_W-1:0]               minLow,
  input  ctlStb_t                       stb,
  output dpEvt_t                        evt,
  output logic [NUM_CH-1:0][CNT_W-1:0]  glitchCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    sgm_edge_timer #(.PW_W(PW_W)) u_timer (
      .clk      (clk),
      .rstN     (rstN),
      .serClkIn (serClk[ch]),
      .armClr   (stb.armClr),
      .minHigh  (minHigh),
      .minLow   (minLow),
      .edgeNow  (evt.edgeSeen[ch]),
      .shortNow (evt.shortLvl[ch])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        glitchCnt[ch] <= '0;
      end else if (stb.cntInc[ch] && (glitchCnt[ch] != CNT_MAX)) begin
        glitchCnt[ch] <= glitchCnt[ch] + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sgm_ctrl.sv
module sgm_ctrl
  import sgm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              detEn,
  input  logic [NUM_CH-1:0] irqMask,
  input  logic [NUM_CH-1:0] flagClr,
  input  dpEvt_t            evt,
  output ctlStb_t           stb,
  output logic [NUM_CH-1:0] glitchFlag,
  output logic              irqOut
);

  logic [NUM_CH-1:0] glitchNow;

  assign glitchNow  = detEn ? (evt.edgeSeen & evt.shortLvl) : '0;
  assign stb.armClr = !detEn;
  assign stb.cntInc = glitchNow;
  assign irqOut     = |(glitchFlag & irqMask);

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) glitchFlag <= '0;
    else       glitchFlag <= glitchNow | (glitchFlag & ~flagClr);
  end

endmodule

// File: rtl/serial_clk_glitch_mon.sv
module serial_clk_glitch_mon
  import sgm_pkg::*;
#(
  parameter int PW_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxSerClk,
  input  logic             txSerClk,
  input  logic             glitchDetEn,
  input  logic [PW_W-1:0]  minHighCyc,
  input  logic [PW_W-1:0]  minLowCyc,
  input  logic             rxIrqMask,
  input  logic             txIrqMask,
  input  logic             rxFlagClr,
  input  logic             txFlagClr,
  output logic             rxGlitchFlag,
  output logic             txGlitchFlag,
  output logic             glitchIrq,
  output logic [CNT_W-1:0] rxGlitchCnt,
  output logic [CNT_W-1:0] txGlitchCnt
);

  dpEvt_t                       evt;
  ctlStb_t                      stb;
  logic [NUM_CH-1:0]            flags;
  logic [NUM_CH-1:0][CNT_W-1:0] cnts;
  logic [NUM_CH-1:0]            serClk, masks, clrs;

  assign serClk[CH_RX] = rxSerClk;
  assign serClk[CH_TX] = txSerClk;
  assign masks[CH_RX]  = rxIrqMask;
  assign masks[CH_TX]  = txIrqMask;
  assign clrs[CH_RX]   = rxFlagClr;
  assign clrs[CH_TX]   = txFlagClr;

  sgm_datapath #(.PW_W(PW_W), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .minHigh   (minHighCyc),
    .minLow    (minLowCyc),
    .stb       (stb),
    .evt       (evt),
    .glitchCnt (cnts)
  );

  sgm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .detEn      (glitchDetEn),
    .irqMask    (masks),
    .flagClr    (clrs),
    .evt        (evt),
    .stb        (stb),
    .glitchFlag (flags),
    .irqOut     (glitchIrq)
  );

  assign rxGlitchFlag = flags[CH_RX];
  assign txGlitchFlag = flags[CH_TX];
  assign rxGlitchCnt  = cnts[CH_RX];
  assign txGlitchCnt  = cnts[CH_TX];

endmodule

// File: rtl/serial_clk_glitch_mon_chk.sv
module serial_clk_glitch_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             glitchDetEn,
  input logic             rxIrqMask,
  input logic             txIrqMask,
  input logic             rxFlagClr,
  input logic             txFlagClr,
  input logic             rxGlitchFlag,
  input logic             txGlitchFlag,
  input logic             glitchIrq,
  input logic [CNT_W-1:0] rxGlitchCnt,
  input logic [CNT_W-1:0] txGlitchCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R6
  rx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxGlitchFlag && !rxFlagClr |=> rxGlitchFlag);
  // R6
  tx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    txGlitchFlag && !txFlagClr |=> txGlitchFlag);
  // R8
  rx_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxGlitchCnt == CNT_MAX |=> rxGlitchCnt == CNT_MAX);
  // R8
  tx_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    txGlitchCnt == CNT_MAX |=> txGlitchCnt == CNT_MAX);
  // R5
  off_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    !glitchDetEn |=> $stable(rxGlitchCnt) && $stable(txGlitchCnt));
  // R5
  off_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !glitchDetEn |=> !$rose(rxGlitchFlag) && !$rose(txGlitchFlag));
  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxIrqMask && !txIrqMask |-> !glitchIrq);
  // R3
  rx_cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxGlitchCnt != $past(rxGlitchCnt) |->
      (rxGlitchCnt == $past(rxGlitchCnt) + CNT_W'(1)) && rxGlitchFlag);
  // R4
  tx_cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    txGlitchCnt != $past(txGlitchCnt) |->
      (txGlitchCnt == $past(txGlitchCnt) + CNT_W'(1)) && txGlitchFlag);

endmodule

bind serial_clk_glitch_mon serial_clk_glitch_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .glitchDetEn  (glitchDetEn),
  .rxIrqMask    (rxIrqMask),
  .txIrqMask    (txIrqMask),
  .rxFlagClr    (rxFlagClr),
  .txFlagClr    (txFlagClr),
  .rxGlitchFlag (rxGlitchFlag),
  .txGlitchFlag (txGlitchFlag),
  .glitchIrq    (glitchIrq),
  .rxGlitchCnt  (rxGlitchCnt),
  .txGlitchCnt  (txGlitchCnt)
);

// File: tb/serial_clk_glitch_mon_tb.sv
`timescale 1ns/1ps
module serial_clk_glitch_mon_tb;

  localparam int PW_W    = 8;
  localparam int CNT_W   = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int MIN_HI  = 5;
  localparam int MIN_LO  = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             rxSerClk = 1'b0, txSerClk = 1'b0;
  logic             glitchDetEn = 1'b0;
  logic [PW_W-1:0]  minHighCyc = PW_W'(MIN_HI);
  logic [PW_W-1:0]  minLowCyc  = PW_W'(MIN_LO);
  logic             rxIrqMask = 1'b0, txIrqMask = 1'b0;
  logic             rxFlagClr = 1'b0, txFlagClr = 1'b0;
  logic             rxGlitchFlag, txGlitchFlag, glitchIrq;
  logic [CNT_W-1:0] rxGlitchCnt, txGlitchCnt;

  int errors = 0;
  int checks = 0;
  int rxExp  = 0;
  int txExp  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  serial_clk_glitch_mon #(.PW_W(PW_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .rxSerClk(rxSerClk), .txSerClk(txSerClk),
    .glitchDetEn(glitchDetEn), .minHighCyc(minHighCyc), .minLowCyc(minLowCyc),
    .rxIrqMask(rxIrqMask), .txIrqMask(txIrqMask),
    .rxFlagClr(rxFlagClr), .txFlagClr(txFlagClr),
    .rxGlitchFlag(rxGlitchFlag), .txGlitchFlag(txGlitchFlag),
    .glitchIrq(glitchIrq), .rxGlitchCnt(rxGlitchCnt), .txGlitchCnt(txGlitchCnt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int satInc(input int c);
    return (c >= CNT_MAX) ? CNT_MAX : c + 1;
  endfunction

  // drive a channel to a level and keep it for n samples
  task automatic hold(input int ch, input bit v, input int n);
    if (ch == 0) rxSerClk = v; else txSerClk = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseClr(input int ch);
    if (ch == 0) rxFlagClr = 1'b1; else txFlagClr = 1'b1;
    @(negedge clk);
    rxFlagClr = 1'b0;
    txFlagClr = 1'b0;
  endtask

  task automatic checkRx(input string req, input int flagExp);
    check(rxGlitchFlag == flagExp, req, "rx flag", int'(rxGlitchFlag), flagExp);
    check(int'(rxGlitchCnt) == rxExp, req, "rx count", int'(rxGlitchCnt), rxExp);
  endtask

  task automatic checkTx(input string req, input int flagExp);
    check(txGlitchFlag == flagExp, req, "tx flag", int'(txGlitchFlag), flagExp);
    check(int'(txGlitchCnt) == txExp, req, "tx count", int'(txGlitchCnt), txExp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 during reset
    checkRx("R1", 0);
    checkTx("R1", 0);
    check(glitchIrq == 1'b0, "R1", "irq in reset", int'(glitchIrq), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkRx("R1", 0);
    checkTx("R1", 0);
    glitchDetEn = 1'b1;
    hold(0, 0, 10);

    // R10: exact cycle of the flag update, and set beats clear (R6)
    hold(0, 1, 2);                 // rise: first edge, not judged
    rxSerClk = 1'b0;               // end of 2-cycle high, first sampled next edge
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    checkRx("R10", 0);             // three edges gone, not yet
    rxFlagClr = 1'b1;              // clear lands on the setting edge
    @(negedge clk);
    rxFlagClr = 1'b0;
    rxExp = satInc(rxExp);
    checkRx("R10", 1);
    checkRx("R6", 1);
    hold(0, 0, 20);
    checkRx("R6", 1);              // still sticky
    pulseClr(0);
    checkRx("R6", 0);

    // R3: high-width sweep on rx, R9 tx untouched
    for (int h = 2; h <= 8; h++) begin
      hold(0, 1, h);
      hold(0, 0, 20);
      if (h < MIN_HI) rxExp = satInc(rxExp);
      checkRx("R3", (h < MIN_HI) ? 1 : 0);
      pulseClr(0);
    end
    checkTx("R9", 0);

    // R4: low-width sweep on tx, R9 rx untouched
    hold(1, 1, 20);                // first tx edge, not judged
    for (int l = 2; l <= 7; l++) begin
      hold(1, 0, l);
      hold(1, 1, 20);
      if (l < MIN_LO) txExp = satInc(txExp);
      checkTx("R4", (l < MIN_LO) ? 1 : 0);
      pulseClr(1);
    end
    checkRx("R9", 0);

    // R2: single-sample spikes are filtered out
    hold(0, 1, 1);
    hold(0, 0, 20);
    checkRx("R2", 0);
    hold(1, 0, 1);
    hold(1, 1, 20);
    checkTx("R2", 0);

    // R5: disabled detection ignores a short pulse
    glitchDetEn = 1'b0;
    hold(0, 1, 2);
    hold(0, 0, 20);
    checkRx("R5", 0);
    // R5: first edge after enable is not judged
    minLowCyc = PW_W'(30);
    glitchDetEn = 1'b1;
    hold(0, 0, 5);
    hold(0, 1, 10);                // low of 25 < 30, but unarmed
    checkRx("R5", 0);
    hold(0, 0, 10);                // high 10 >= 5
    checkRx("R5", 0);
    hold(0, 1, 10);                // low 10 < 30, armed now
    rxExp = satInc(rxExp);
    checkRx("R4", 1);
    minLowCyc = PW_W'(MIN_LO);
    hold(0, 0, 20);

    // R7: masks on the interrupt, rx flag set, tx clear
    rxIrqMask = 1'b0; txIrqMask = 1'b0;
    @(negedge clk);
    check(glitchIrq == 1'b0, "R7", "irq masks 00", int'(glitchIrq), 0);
    txIrqMask = 1'b1;
    @(negedge clk);
    check(glitchIrq == 1'b0, "R7", "irq tx mask only", int'(glitchIrq), 0);
    rxIrqMask = 1'b1; txIrqMask = 1'b0;
    @(negedge clk);
    check(glitchIrq == 1'b1, "R7", "irq rx mask", int'(glitchIrq), 1);
    checkRx("R7", 1);
    pulseClr(0);
    check(glitchIrq == 1'b0, "R7", "irq after clear", int'(glitchIrq), 0);
    rxIrqMask = 1'b0; txIrqMask = 1'b1;
    hold(1, 0, 2);
    hold(1, 1, 20);
    txExp = satInc(txExp);
    check(glitchIrq == 1'b1, "R7", "irq tx flag", int'(glitchIrq), 1);
    pulseClr(1);
    txIrqMask = 1'b0;

    // R8: saturation of the rx counter
    for (int k = 0; k < CNT_MAX + 2; k++) begin
      hold(0, 1, 2);
      hold(0, 0, 8);
      rxExp = satInc(rxExp);
    end
    checkRx("R8", 1);
    check(int'(rxGlitchCnt) == CNT_MAX, "R8", "rx count at ceiling",
          int'(rxGlitchCnt), CNT_MAX);
    checkTx("R9", 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule